// File: doc/BRIEF.md
# UART Transmit Flow-Control Gate

This block sits between a UART's transmit serializer and the outside world and decides, one character at a time, whether the serializer may begin sending. A 6-bit select mask names which conditions must all be asserted for transmission to go on. The conditions are four modem status inputs, a software transmit enable, and an in-band flow-control flag that follows XON/XOFF bytes seen on the receive side. When any selected condition is deasserted, the gate stops granting new characters. A character that is already being shifted out always finishes, so a halt only takes effect at a character boundary.

The block also produces the outgoing request-to-send line. It either passes the UART's own RTS through, or drives RTS from the receive FIFO fill level, dropping it whenever the FIFO is at least half full. A remote loopback switch can replace the UART's transmit data with the receive serial data.

The grant logic is a three-state machine. S_HALTED means no grant is given. S_READY means the gate is waiting for a character. S_SHIFT means a character is in flight. The transitions are:

- HALTED->READY when the gate is permitted.
- READY->HALTED when permission is lost.
- READY->SHIFT on a request while permitted. This transition emits a one-cycle start pulse.
- SHIFT->READY or SHIFT->HALTED on the serializer's done pulse, chosen by the permission at that moment.

Top module: `uart_txgate`

## Requirements
- R1: After reset the mask is 6'b010000, so only the software enable is selected. With sw_tx_en low the gate is in S_HALTED (tx_halted=1, tx_start=0), and raising sw_tx_en alone lets it reach S_READY even though the modem inputs are low.
- R2: The mask bit positions are fixed: bit0 CTS, bit1 DCD, bit2 DSR, bit3 RI, bit4 software enable, bit5 in-band flow control (active when not stopped). The gate is permitted only when every selected condition is asserted, and it halts when any selected condition is deasserted.
- R3: A condition whose mask bit is 0 has no effect on tx_halted.
- R4: Each modem input passes through a two-flop synchronizer, so tx_halted reflects a change on it three rising edges after the change and not after two.
- R5: Receiving byte 8'h13 (rx_char_valid high) sets the stopped flag, receiving 8'h11 clears it, and any other byte leaves it unchanged. The flag gates transmission only while mask bit5 is set, and it takes effect on tx_halted two edges after the byte.
- R6: While in S_SHIFT the gate stays there until tx_done, whatever the conditions do and whatever tx_req does. On tx_done it moves to S_READY if permitted, or to S_HALTED otherwise.
- R7: tx_start is a registered one-cycle pulse, raised on the edge at which tx_req is high in S_READY while permitted. tx_active is high in S_SHIFT.
- R8: A write (cfg_wr high) loads cfg_mask into the mask on that edge.
- R9: txd_out equals rxd_in when rl_en=1 and uart_txd when rl_en=0, with no clock delay.
- R10: With rts_mode=0, rts_out follows uart_rts. With rts_mode=1, rts_out is 1 when rx_level is below RXF_DEPTH/2 and 0 otherwise. RTS is active-high and combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load cfg_mask into the select mask |
| cfg_mask | input | 6 | New select mask value |
| sw_tx_en | input | 1 | Software transmit enable |
| cts_in | input | 1 | Clear-to-send, asserted high, asynchronous |
| dcd_in | input | 1 | Carrier detect, asserted high, asynchronous |
| dsr_in | input | 1 | Data set ready, asserted high, asynchronous |
| ri_in | input | 1 | Ring indicator, asserted high, asynchronous |
| rx_char_valid | input | 1 | A received byte is present on rx_char |
| rx_char | input | 8 | Received byte, scanned for XON/XOFF |
| tx_req | input | 1 | Serializer has a character waiting |
| tx_done | input | 1 | Serializer finished the current character |
| tx_start | output | 1 | One-cycle grant to start a character |
| tx_active | output | 1 | A granted character is in flight |
| tx_halted | output | 1 | Gate is in the halted state |
| rts_mode | input | 1 | 0: pass UART RTS, 1: RTS from FIFO level |
| rx_level | input | LVL_W (7) | Receive FIFO fill count |
| uart_rts | input | 1 | RTS from the UART |
| rts_out | output | 1 | Request-to-send to the line |
| rl_en | input | 1 | Remote loopback enable |
| rxd_in | input | 1 | Receive serial data |
| uart_txd | input | 1 | Transmit serial data from the UART |
| txd_out | output | 1 | Transmit serial data to the line |

## Verification
Each result is due after its own number of rising edges. The loopback and RTS outputs respond within the same cycle. A software-enable change and a tx_req or tx_done pulse show up one edge later. A mask write or an XON/XOFF byte shows up two edges later, and a modem input three edges later. The bench drives every input on the falling edge and samples on a later falling edge after exactly the edge count that applies. For the modem inputs it also samples one edge early, to show the synchronizer delay. The random phase waits four edges after each change before comparing tx_halted with a bench-computed permission, so it does not depend on which latency applies.

// File: rtl/txg_pkg.sv
package txg_pkg;
    localparam int unsigned MASK_W  = 6;
    localparam int unsigned MB_CTS  = 0;
    localparam int unsigned MB_DCD  = 1;
    localparam int unsigned MB_DSR  = 2;
    localparam int unsigned MB_RI   = 3;
    localparam int unsigned MB_SW   = 4;
    localparam int unsigned MB_INB  = 5;
    localparam logic [MASK_W-1:0] MASK_RST = 6'b010000;

    typedef enum logic [1:0] {
        S_HALTED = 2'd0,
        S_READY  = 2'd1,
        S_SHIFT  = 2'd2
    } gate_st_t;
endpackage

// File: rtl/txg_sync2.sv
module txg_sync2 #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        logic meta_q, stab_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d[i];
                stab_q <= meta_q;
            end
        end
        assign q[i] = stab_q;
    end
endmodule

// File: rtl/txg_inband.sv
module txg_inband #(
    parameter logic [7:0] XON_CHAR  = 8'h11,
    parameter logic [7:0] XOFF_CHAR = 8'h13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_char_valid,
    input  logic [7:0] rx_char,
    output logic       stopped
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            stopped <= 1'b0;
        else if (rx_char_valid && rx_char == XOFF_CHAR)
            stopped <= 1'b1;
        else if (rx_char_valid && rx_char == XON_CHAR)
            stopped <= 1'b0;
    end

    a_r5_xoff_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_valid && rx_char == XOFF_CHAR) |=> stopped);
    a_r5_xon_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_valid && rx_char == XON_CHAR) |=> !stopped);
    a_r5_other_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_char_valid || (rx_char != XON_CHAR && rx_char != XOFF_CHAR)) |=> $stable(stopped));
endmodule

// File: rtl/txg_linepath.sv
module txg_linepath #(
    parameter int unsigned RXF_DEPTH = 64,
    localparam int unsigned LVL_W = $clog2(RXF_DEPTH + 1)
) (
    input  logic             rts_mode,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             uart_rts,
    output logic             rts_out,
    input  logic             rl_en,
    input  logic             rxd_in,
    input  logic             uart_txd,
    output logic             txd_out
);
    localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(RXF_DEPTH / 2);

    logic fifo_room;
    assign fifo_room = (rx_level < HALF_LVL);
    assign rts_out   = rts_mode ? fifo_room : uart_rts;
    assign txd_out   = rl_en ? rxd_in : uart_txd;

    always_comb begin
        if (rts_mode && rx_level >= HALF_LVL)
            a_r10_rts_drop: assert (rts_out == 1'b0);
        if (rl_en)
            a_r9_loop: assert (txd_out == rxd_in);
    end
endmodule

// File: rtl/uart_txgate.sv
module uart_txgate
    import txg_pkg::*;
#(
    parameter int unsigned RXF_DEPTH = 64,
    parameter logic [7:0]  XON_CHAR  = 8'h11,
    parameter logic [7:0]  XOFF_CHAR = 8'h13,
    localparam int unsigned LVL_W = $clog2(RXF_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [5:0]       cfg_mask,
    input  logic             sw_tx_en,
    input  logic             cts_in,
    input  logic             dcd_in,
    input  logic             dsr_in,
    input  logic             ri_in,
    input  logic             rx_char_valid,
    input  logic [7:0]       rx_char,
    input  logic             tx_req,
    input  logic             tx_done,
    output logic             tx_start,
    output logic             tx_active,
    output logic             tx_halted,
    input  logic             rts_mode,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             uart_rts,
    output logic             rts_out,
    input  logic             rl_en,
    input  logic             rxd_in,
    input  logic             uart_txd,
    output logic             txd_out
);
    logic [MASK_W-1:0] mask_q;
    logic [3:0]        modem_s;
    logic              inb_stopped;
    logic [MASK_W-1:0] cond;
    logic              permit;
    gate_st_t          state_q, state_d;
    logic              start_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= MASK_RST;
        else if (cfg_wr)
            mask_q <= cfg_mask;
    end

    txg_sync2 #(.WIDTH(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ri_in, dsr_in, dcd_in, cts_in}),
        .q     (modem_s)
    );

    txg_inband #(.XON_CHAR(XON_CHAR), .XOFF_CHAR(XOFF_CHAR)) u_inband (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_char_valid (rx_char_valid),
        .rx_char       (rx_char),
        .stopped       (inb_stopped)
    );

    txg_linepath #(.RXF_DEPTH(RXF_DEPTH)) u_line (
        .rts_mode (rts_mode),
        .rx_level (rx_level),
        .uart_rts (uart_rts),
        .rts_out  (rts_out),
        .rl_en    (rl_en),
        .rxd_in   (rxd_in),
        .uart_txd (uart_txd),
        .txd_out  (txd_out)
    );

    always_comb begin
        cond         = '0;
        cond[MB_CTS] = modem_s[0];
        cond[MB_DCD] = modem_s[1];
        cond[MB_DSR] = modem_s[2];
        cond[MB_RI]  = modem_s[3];
        cond[MB_SW]  = sw_tx_en;
        cond[MB_INB] = ~inb_stopped;
    end
    assign permit = &(~mask_q | cond);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_HALTED;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= (state_q == S_READY) && permit && tx_req;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HALTED: if (permit) state_d = S_READY;
            S_READY: begin
                if (!permit)     state_d = S_HALTED;
                else if (tx_req) state_d = S_SHIFT;
            end
            S_SHIFT: if (tx_done) state_d = permit ? S_READY : S_HALTED;
            default: state_d = S_HALTED;
        endcase
    end

    // outputs
    always_comb begin
        tx_start  = start_q;
        tx_active = (state_q == S_SHIFT);
        tx_halted = (state_q == S_HALTED);
    end

    a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
    a_r7_start_enters_shift: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> tx_active);
    a_r2_start_permitted: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(permit));
    a_r6_shift_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !tx_done) |=> tx_active);
    a_r6_done_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && tx_done) |=> !tx_active);
endmodule

// File: tb/uart_txgate_tb.sv
module uart_txgate_tb;
    localparam int unsigned DEPTH = 64;
    localparam int unsigned LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, sw_tx_en = 0, cts_in = 0, dcd_in = 0, dsr_in = 0, ri_in = 0;
    logic [5:0] cfg_mask = '0;
    logic rx_char_valid = 0;
    logic [7:0] rx_char = '0;
    logic tx_req = 0, tx_done = 0, rts_mode = 0, uart_rts = 0, rl_en = 0, rxd_in = 0, uart_txd = 0;
    logic [LW-1:0] rx_level = '0;
    logic tx_start, tx_active, tx_halted, rts_out, txd_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic model_stop = 0;

    always #10 clk = ~clk;

    uart_txgate #(.RXF_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mask(cfg_mask),
        .sw_tx_en(sw_tx_en), .cts_in(cts_in), .dcd_in(dcd_in), .dsr_in(dsr_in),
        .ri_in(ri_in), .rx_char_valid(rx_char_valid), .rx_char(rx_char),
        .tx_req(tx_req), .tx_done(tx_done), .tx_start(tx_start),
        .tx_active(tx_active), .tx_halted(tx_halted), .rts_mode(rts_mode),
        .rx_level(rx_level), .uart_rts(uart_rts), .rts_out(rts_out),
        .rl_en(rl_en), .rxd_in(rxd_in), .uart_txd(uart_txd), .txd_out(txd_out)
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_mask(logic [5:0] m);
        cfg_mask = m; cfg_wr = 1; step(1); cfg_wr = 0;
    endtask

    task automatic send_char(logic [7:0] b);
        rx_char = b; rx_char_valid = 1; step(1); rx_char_valid = 0;
        if (b == 8'h13) model_stop = 1;
        else if (b == 8'h11) model_stop = 0;
    endtask

    function automatic logic exp_permit(logic [5:0] m, logic c, logic d, logic s,
                                        logic r, logic sw, logic stop);
        logic [5:0] cv;
        cv = {~stop, sw, r, s, d, c};
        return &(~m | cv);
    endfunction

    function automatic logic exp_rts(logic mode, logic [LW-1:0] lvl, logic u);
        return mode ? (lvl < LW'(DEPTH / 2)) : u;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1;
        step(1);
        // R1: reset state
        chk("R1 halted after reset", tx_halted, 1);
        chk("R1 no start after reset", tx_start, 0);
        sw_tx_en = 1; step(1);
        chk("R1 default mask selects only sw", tx_halted, 0);

        // R4: synchronizer latency on CTS
        wr_mask(6'b000001); cts_in = 1; step(3);
        chk("R4 cts asserted ready", tx_halted, 0);
        cts_in = 0; step(2);
        chk("R4 not yet halted after 2 edges", tx_halted, 0);
        step(1);
        chk("R4 halted after 3 edges", tx_halted, 1);

        // R3: unselected conditions ignored
        cts_in = 1; sw_tx_en = 0; dcd_in = 0; dsr_in = 0; ri_in = 0;
        send_char(8'h13);
        step(3);
        chk("R3 unselected sw/modem/xoff ignored", tx_halted, 0);
        send_char(8'h11);

        // R5: in-band flow control
        wr_mask(6'b100000);
        step(1);
        chk("R5 not stopped initially", tx_halted, 0);
        send_char(8'h13); step(1);
        chk("R5 XOFF halts after 2 edges", tx_halted, 1);
        send_char(8'h41); step(2);
        chk("R5 other byte keeps stopped", tx_halted, 1);
        send_char(8'h11); step(1);
        chk("R5 XON resumes", tx_halted, 0);

        // R8 + R2: mask write then each selected modem input
        wr_mask(6'b001110); dcd_in = 1; dsr_in = 1; ri_in = 1; step(3);
        chk("R8 new mask, all selected asserted", tx_halted, 0);
        dsr_in = 0; step(3);
        chk("R2 one selected deasserted halts", tx_halted, 1);
        dsr_in = 1; step(3);

        // R6/R7: character boundary
        wr_mask(6'b010000); sw_tx_en = 1; step(1);
        tx_req = 1; step(1);
        chk("R7 start pulse", tx_start, 1);
        chk("R7 active in shift", tx_active, 1);
        sw_tx_en = 0; step(1);
        chk("R7 pulse lasts one cycle", tx_start, 0);
        step(2);
        chk("R6 shift survives halt", tx_active, 1);
        chk("R6 not halted mid-char", tx_halted, 0);
        tx_done = 1; step(1); tx_done = 0;
        chk("R6 done without permit halts", tx_halted, 1);
        chk("R7 no start while halted", tx_start, 0);
        sw_tx_en = 1; step(2);
        chk("R7 start after resume", tx_start, 1);
        tx_req = 0;
        tx_done = 1; step(1); tx_done = 0;
        chk("R6 done with permit to ready", {30'd0, tx_active, tx_halted}, 0);

        // R9/R10 directed boundaries
        rts_mode = 1; rx_level = LW'(DEPTH / 2 - 1); #1;
        chk("R10 below half asserts rts", rts_out, 1);
        rx_level = LW'(DEPTH / 2); #1;
        chk("R10 at half drops rts", rts_out, 0);
        rts_mode = 0; uart_rts = 1; #1;
        chk("R10 passthrough", rts_out, 1);
        rl_en = 1; rxd_in = 1; uart_txd = 0; #1;
        chk("R9 loopback selects rxd", txd_out, 1);
        rl_en = 0; #1;
        chk("R9 normal selects uart_txd", txd_out, 0);

        // Random phase (R2, R9, R10)
        for (int it = 0; it < 300; it++) begin
            logic [5:0] m;
            logic [7:0] b;
            int pick;
            step(1);
            m = 6'($urandom);
            wr_mask(m);
            cts_in = 1'($urandom); dcd_in = 1'($urandom);
            dsr_in = 1'($urandom); ri_in = 1'($urandom);
            sw_tx_en = 1'($urandom);
            rts_mode = 1'($urandom); uart_rts = 1'($urandom);
            rx_level = LW'($urandom_range(0, DEPTH));
            rl_en = 1'($urandom); rxd_in = 1'($urandom); uart_txd = 1'($urandom);
            #1;
            chk("R9 random txd", txd_out, rl_en ? rxd_in : uart_txd);
            chk("R10 random rts", rts_out, exp_rts(rts_mode, rx_level, uart_rts));
            pick = $urandom_range(0, 3);
            b = (pick == 0) ? 8'h13 : (pick == 1) ? 8'h11 : 8'($urandom);
            if (pick != 3) send_char(b); else step(1);
            step(3);
            chk("R2 random permit", tx_halted,
                !exp_permit(m, cts_in, dcd_in, dsr_in, ri_in, sw_tx_en, model_stop));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule